// File: doc/BRIEF.md
# Unlock-Sequence Write Gate

This block stands between the host write path and the page load controller of a byte-wide non-volatile store. Each host write arrives as one cycle of `wr_valid` with its address and data. The block decides whether that write may start, or join, a page load. It keeps a sticky protection flag. While the flag is set, a page load can open only after three exact command writes, one after another. The first is address 5555h with data AAh, the second is address 2AAAh with data 55h, and the third is address 5555h with data A0h. Writes that are not allowed through are dropped quietly, so a stray write on a noisy supply edge never reaches the page buffer.

The flag comes out of reset in the state set by `PROT_AT_RESET`, which defaults to set. The flag is also set when the unlock sequence runs while it is clear, and after that it never clears. Once a page load is open, every host write is forwarded to the page buffer on the `buf_*` outputs. This includes writes that look like command bytes. The page load controller pulses `load_end` when its load window closes. That pulse shuts the window, and the next page needs a fresh sequence. The three command writes are never forwarded.

The state machine has four states. In IDLE, a write that matches step one moves to KEY1. KEY1 moves to KEY2 on a step-two match. KEY2 moves to OPEN on a step-three match and sets the flag. Any other write in KEY1 or KEY2 takes the unlock-abort transition back to IDLE. When the flag is clear, a write in IDLE that does not match step one takes the direct-open transition to OPEN and is forwarded. OPEN takes the window-close transition back to IDLE on `load_end`.

Top module: `wrprot_gate`

## Requirements
- R1: After reset, `load_permit` and `buf_wr` are 0. `prot_on` equals `PROT_AT_RESET`, which is 1 by default.
- R2: With protection on, the writes 5555h/AAh, 2AAAh/55h and 5555h/A0h on three consecutive accepted write cycles raise `load_permit` in the cycle after the third write. None of the three writes raises `buf_wr`.
- R3: While `load_permit` is 1, each write is forwarded. `buf_wr` is 1 in the following cycle, and `buf_addr`/`buf_data` carry that write's address and data. This holds even when the write matches a command pattern.
- R4: With protection on and no window open, a write that is not part of a correct unlock sequence raises neither `buf_wr` nor `load_permit`.
- R5: A write that does not match the expected next step returns the sequencer to IDLE and is not forwarded. This includes a repeated step-one write. The next page load then needs the full three-write sequence from the start.
- R6: A `load_end` pulse while the window is open clears `load_permit` in the next cycle. With protection on, a later write is then dropped until a new sequence completes.
- R7: `load_end` outside an open window has no effect. A partly entered sequence continues past it.
- R8: With protection off, a write that does not match step one is forwarded, and it opens the window (`load_permit` becomes 1).
- R9: Completing the unlock sequence while protection is off sets `prot_on` and opens the window. From then on `prot_on` stays 1, and later pages need the sequence.
- R10: A write in the same cycle as `load_end` in an open window is still forwarded, and the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One latched host write this cycle |
| wr_addr | input | ADDR_W | Address of the latched write |
| wr_data | input | DATA_W | Data of the latched write |
| load_end | input | 1 | Page load window has closed (pulse) |
| load_permit | output | 1 | Page load is open; writes are accepted |
| prot_on | output | 1 | Protection flag |
| buf_wr | output | 1 | Forwarded write strobe to the page buffer |
| buf_addr | output | ADDR_W | Forwarded write address |
| buf_data | output | DATA_W | Forwarded write data |

## Verification
The bench sends a repeated step-one write in the middle of the sequence. A design that treats a repeat as a restart would open the window where it should stay closed. The bench also sends a wrong third step and a `load_end` pulse in the middle of the sequence. A design that ignored the first case, or reset on the second, would forward data or refuse a valid unlock. It checks that command-shaped bytes inside an open window are forwarded as data, and that a write coinciding with `load_end` is kept. A second instance built with protection off covers the direct-open path and the sticky setting of the flag. A design that never set the flag, or later cleared it, would go on forwarding unguarded writes.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
    localparam int NSTEP = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY1 = 2'd1,
        ST_KEY2 = 2'd2,
        ST_OPEN = 2'd3
    } gate_st_t;
endpackage

// File: rtl/wrprot_match.sv
module wrprot_match #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int NSTEP  = 3,
    parameter logic [NSTEP*ADDR_W-1:0] STEP_ADDR = '0,
    parameter logic [NSTEP*DATA_W-1:0] STEP_DATA = '0
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NSTEP-1:0]  hit
);
    for (genvar i = 0; i < NSTEP; i++) begin : g_step
        assign hit[i] = wr_valid
                     && (wr_addr == STEP_ADDR[i*ADDR_W +: ADDR_W])
                     && (wr_data == STEP_DATA[i*DATA_W +: DATA_W]);
    end
endmodule

// File: rtl/wrprot_fsm.sv
module wrprot_fsm
    import wrprot_pkg::*;
#(
    parameter bit PROT_AT_RESET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [NSTEP-1:0] hit,
    input  logic             load_end,
    output logic             fwd,
    output logic             load_permit,
    output logic             prot_on
);
    gate_st_t state, nxt;
    logic     set_prot;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and forward decision
    always_comb begin
        nxt      = state;
        set_prot = 1'b0;
        fwd      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_valid) begin
                    if (hit[0]) begin
                        nxt = ST_KEY1;
                    end else if (!prot_on) begin
                        nxt = ST_OPEN;
                        fwd = 1'b1;
                    end
                end
            end
            ST_KEY1: begin
                if (wr_valid) nxt = hit[1] ? ST_KEY2 : ST_IDLE;
            end
            ST_KEY2: begin
                if (wr_valid) begin
                    if (hit[2]) begin
                        nxt      = ST_OPEN;
                        set_prot = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_OPEN: begin
                fwd = wr_valid;
                if (load_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_permit <= 1'b0;
            prot_on     <= PROT_AT_RESET;
        end else begin
            load_permit <= (nxt == ST_OPEN);
            prot_on     <= prot_on | set_prot;
        end
    end

    // R2: under protection the window opens only on the third key
    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_permit) && $past(prot_on)) |-> $past(hit[2]));

    // R9: protection never clears once set
    a_r9_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |=> prot_on);

    // R6: end of window closes permit
    a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
        (load_permit && load_end) |=> !load_permit);

    // R7: load_end with no window and no write changes nothing
    a_r7_end_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_permit && load_end && !wr_valid) |=> ($stable(state) && !load_permit));
endmodule

// File: rtl/wrprot_fwd.sv
module wrprot_fwd #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              buf_wr,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_wr   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
        end else begin
            buf_wr <= fwd;
            if (fwd) begin
                buf_addr <= wr_addr;
                buf_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/wrprot_gate.sv
module wrprot_gate
    import wrprot_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter bit PROT_AT_RESET = 1'b1,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_A = 'h5555,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR_B = 'h2AAA,
    parameter logic [DATA_W-1:0] KEY_1 = 'hAA,
    parameter logic [DATA_W-1:0] KEY_2 = 'h55,
    parameter logic [DATA_W-1:0] KEY_3 = 'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_end,
    output logic              load_permit,
    output logic              prot_on,
    output logic              buf_wr,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data
);
    localparam logic [NSTEP*ADDR_W-1:0] STEP_ADDR = {UNLOCK_ADDR_A, UNLOCK_ADDR_B, UNLOCK_ADDR_A};
    localparam logic [NSTEP*DATA_W-1:0] STEP_DATA = {KEY_3, KEY_2, KEY_1};

    logic [NSTEP-1:0] hit;
    logic             fwd;

    wrprot_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTEP(NSTEP),
        .STEP_ADDR(STEP_ADDR), .STEP_DATA(STEP_DATA)
    ) u_match (
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit)
    );

    wrprot_fsm #(.PROT_AT_RESET(PROT_AT_RESET)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .hit(hit),
        .load_end(load_end), .fwd(fwd), .load_permit(load_permit), .prot_on(prot_on)
    );

    wrprot_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .fwd(fwd), .wr_addr(wr_addr), .wr_data(wr_data),
        .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    // R3: an open window forwards each write intact one cycle later
    a_r3_fwd_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && load_permit) |=>
            (buf_wr && buf_addr == $past(wr_addr) && buf_data == $past(wr_data)));

    // R4: protected and closed means nothing reaches the buffer
    a_r4_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && prot_on && !load_permit) |=> !buf_wr);
endmodule

// File: tb/wrprot_gate_tb.sv
module wrprot_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]    v, le;
    logic [AW-1:0] a [2];
    logic [DW-1:0] d [2];
    logic [1:0]    pm, pr, bw;
    logic [AW-1:0] ba [2];
    logic [DW-1:0] bd [2];

    wrprot_gate #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(v[0]), .wr_addr(a[0]), .wr_data(d[0]),
        .load_end(le[0]), .load_permit(pm[0]), .prot_on(pr[0]), .buf_wr(bw[0]),
        .buf_addr(ba[0]), .buf_data(bd[0]));

    wrprot_gate #(.ADDR_W(AW), .DATA_W(DW), .PROT_AT_RESET(1'b0)) u_dut_open (
        .clk(clk), .rst_n(rst_n), .wr_valid(v[1]), .wr_addr(a[1]), .wr_data(d[1]),
        .load_end(le[1]), .load_permit(pm[1]), .prot_on(pr[1]), .buf_wr(bw[1]),
        .buf_addr(ba[1]), .buf_data(bd[1]));

    typedef struct {
        int            sel;
        bit            e_bw, e_pm, e_pr;
        logic [AW-1:0] e_a;
        logic [DW-1:0] e_d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    task automatic drive(input int sel, input bit wv, input logic [AW-1:0] wa,
                         input logic [DW-1:0] wd, input bit we,
                         input bit xbw, input bit xpm, input bit xpr, input string tag);
        exp_t e;
        @(negedge clk);
        e.sel = sel; e.e_bw = xbw; e.e_pm = xpm; e.e_pr = xpr;
        e.e_a = wa; e.e_d = wd; e.tag = tag;
        q.push_back(e);
        v = '0; le = '0;
        v[sel] = wv; le[sel] = we; a[sel] = wa; d[sel] = wd;
    endtask

    task automatic unlock(input int sel, input bit xpr_last, input string tag);
        drive(sel, 1, 17'h05555, 8'hAA, 0, 0, 0, xpr_last ? 1'b1 : pr_now(sel), tag);
        drive(sel, 1, 17'h02AAA, 8'h55, 0, 0, 0, xpr_last ? 1'b1 : pr_now(sel), tag);
        drive(sel, 1, 17'h05555, 8'hA0, 0, 0, 1, 1, tag);
    endtask

    // protection level the bench expects before the final key (sel 1 starts off)
    bit open_prot = 0;
    function automatic bit pr_now(input int sel);
        return (sel == 0) ? 1'b1 : open_prot;
    endfunction

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            n_vec++;
            ok = (bw[e.sel] == e.e_bw) && (pm[e.sel] == e.e_pm) && (pr[e.sel] == e.e_pr);
            if (e.e_bw) ok = ok && (ba[e.sel] == e.e_a) && (bd[e.sel] == e.e_d);
            if (!ok) begin
                n_bad++;
                $display("FAIL %s dut%0d: got wr=%0b permit=%0b prot=%0b a=%h d=%h exp wr=%0b permit=%0b prot=%0b a=%h d=%h",
                         e.tag, e.sel, bw[e.sel], pm[e.sel], pr[e.sel], ba[e.sel], bd[e.sel],
                         e.e_bw, e.e_pm, e.e_pr, e.e_a, e.e_d);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        v = '0; le = '0;
        a[0] = '0; a[1] = '0; d[0] = '0; d[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both instances
        drive(0, 0, 0, 0, 0, 0, 0, 1, "R1");
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R4: plain write while locked
        drive(0, 1, 17'h00123, 8'h11, 0, 0, 0, 1, "R4");

        // R5: repeated first key aborts; the rest no longer opens
        drive(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h05555, 8'hA0, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h00200, 8'h22, 0, 0, 0, 1, "R5");
        // R5: wrong third key
        drive(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h05555, 8'hA1, 0, 0, 0, 1, "R5");
        drive(0, 1, 17'h00201, 8'h23, 0, 0, 0, 1, "R5");

        // R7: load_end while idle, and in mid sequence, is ignored
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R7");
        drive(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 1, "R7");
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R7");
        drive(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 1, "R7");
        // R2: third key opens the window, no command forwarded
        drive(0, 1, 17'h05555, 8'hA0, 0, 0, 1, 1, "R2");

        // R3: data forwarded, command-shaped byte too
        drive(0, 1, 17'h00080, 8'h5A, 0, 1, 1, 1, "R3");
        drive(0, 1, 17'h05555, 8'hAA, 0, 1, 1, 1, "R3");
        drive(0, 0, 0, 0, 0, 0, 1, 1, "R3");

        // R6: close window; next write dropped
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R6");
        drive(0, 1, 17'h00081, 8'h33, 0, 0, 0, 1, "R6");

        // R10: write together with load_end is kept, window closes
        unlock(0, 1, "R2");
        drive(0, 1, 17'h00090, 8'h77, 1, 1, 0, 1, "R10");
        drive(0, 1, 17'h00091, 8'h78, 0, 0, 0, 1, "R10");

        // R8: unprotected instance, direct open
        drive(1, 1, 17'h00010, 8'h44, 0, 1, 1, 0, "R8");
        drive(1, 1, 17'h00011, 8'h45, 0, 1, 1, 0, "R8");
        drive(1, 0, 0, 0, 1, 0, 0, 0, "R8");

        // R9: sequence while unprotected sets protection
        open_prot = 0;
        unlock(1, 0, "R9");
        drive(1, 1, 17'h00012, 8'h66, 0, 1, 1, 1, "R9");
        drive(1, 0, 0, 0, 1, 0, 0, 1, "R9");
        drive(1, 1, 17'h00013, 8'h01, 0, 0, 0, 1, "R9");
        drive(1, 0, 0, 0, 0, 0, 0, 1, "R9");

        @(negedge clk);
        v = '0; le = '0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule